// File: doc/BRIEF.md
# Power-Down Clock Gate and Wake Controller

This block puts a serial bus interface into a low-power state and brings it back out. The host asks for power-down by setting a bit in a status/control transfer. If the request is allowed, the clock to the interface core stops when that transfer ends. Entry is allowed only while the IDLE status is low, or on the first transfer after reset. A ready level high during the requesting transfer cancels the request.

While the core clock is stopped, a small always-clocked wake section watches three inputs through a two-flop synchronizer:
- the bus receive line falling low,
- the status strobe rising,
- the ready line going high.

Any one of these restarts the gated clock without a glitch. A wake from the host side (strobe edge or ready) returns straight to normal operation. A wake from the bus line is first qualified. If the line stays low long enough, it counts as real bus activity. If it goes high early, it was noise, and the controller restarts from its top state with a fixed IDLE pulse.

The IDLE output stays driven while the core is asleep, so the host can confirm that entry succeeded.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: During and after synchronous reset, `core_clk_en` is 1. `idle_o` is 1 during reset and for IDLE_PULSE_CYC (default 4) cycles after reset is released. It then falls to 0 while `bus_rx` is high.
- R2: A transfer ends on the first clock where `ctl_active` is sampled 0 after being 1. If an allowed power-down request ends this way, `core_clk_en` becomes 0 one cycle after the end and not earlier. `idle_o` is 0 while asleep, and `core_clk` makes no rising edges while asleep.
- R3: Power-down is honoured only if `idle_o` is 0 at the end of the transfer, or if the transfer is the first one since reset. Otherwise the request is ignored and `core_clk_en` stays 1.
- R4: If the synchronized ready input is high during, or at the end of, the requesting transfer, the request is dropped and `core_clk_en` stays 1.
- R5: While asleep, a low level on `bus_rx` sets `core_clk_en` to 1 three clocks after the input changes (two synchronizer stages plus the state register).
- R6: While asleep, a 0-to-1 edge on `stat_strb` wakes the block with the same three-clock latency and returns it to normal operation. A strobe that is already high when sleep begins does not wake it.
- R7: While asleep, a high level on `rdy_in` wakes the block with the same three-clock latency.
- R8: If a bus-line wake is followed by the line returning high before VALID_LOW_CYC (default 8) synchronized low samples, `idle_o` is 1 from the wake through IDLE_PULSE_CYC cycles of recycle. It then returns to 0.
- R9: If the bus line stays low for VALID_LOW_CYC synchronized samples after a wake, normal operation resumes without a recycle pulse. `idle_o` then falls two clocks after the line returns high.
- R10: In normal operation, `idle_o` is 1 while the synchronized `bus_rx` is low, with two clocks of latency in each direction.
- R11: A transfer whose power-down bit is 0 never stops the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock; the wake section always runs on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_rx | input | 1 | Bus receive line, high when the bus is quiet |
| stat_strb | input | 1 | Host status strobe; a rising edge wakes the block |
| rdy_in | input | 1 | Host ready line; a high level wakes the block or cancels entry |
| ctl_active | input | 1 | High for the duration of a status/control transfer |
| ctl_pd | input | 1 | Power-down bit carried by the transfer, sampled while `ctl_active` is high |
| core_clk | output | 1 | Gated clock for the interface core |
| core_clk_en | output | 1 | 1 while the core clock runs |
| idle_o | output | 1 | IDLE status: high while the bus is busy or the controller is recycling |

## Verification
The hardest case to reach is a bus-line wake that is only noise. The line must drop after the clock has stopped and then return high within the qualification window, so the controller takes the recycle path instead of resuming. The stimulus first puts the block to sleep with an allowed request, then pulls the bus line low for just two cycles. It checks the clock enable at the exact synchronizer latency and the IDLE pulse length from its first to its last cycle. A second run holds the line low past the window, to show the other branch, where no pulse appears. The first-after-reset exception is reached by issuing a request on the very clock reset is released, while IDLE is still high from the reset pulse.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    // Positions of the wake inputs in the synchronized vector
    localparam int unsigned PDW_NUM_IN = 3;
    localparam int unsigned IDX_BUS    = 0;
    localparam int unsigned IDX_STAT   = 1;
    localparam int unsigned IDX_RDY    = 2;

    // Quiet value of each wake input, used as the synchronizer reset value
    localparam logic [PDW_NUM_IN-1:0] PDW_QUIET = 3'b001;

    typedef enum logic [1:0] {
        PS_RECYCLE = 2'd0,   // top of controller, IDLE held high for a fixed time
        PS_RUN     = 2'd1,   // normal operation
        PS_SLEEP   = 2'd2,   // core clock stopped
        PS_QUALIFY = 2'd3    // bus-line wake, deciding activity versus noise
    } pdw_state_e;

    typedef struct packed {
        logic bus_low;
        logic stat_rise;
        logic rdy_high;
    } pdw_wake_t;

    typedef struct packed {
        logic end_evt;   // a status/control transfer finished this cycle
        logic pd_ok;     // it requested power-down and entry is allowed
    } pdw_entry_t;

    // Host-side wake causes need no qualification
    function automatic logic host_wake(pdw_wake_t w);
        return w.stat_rise | w.rdy_high;
    endfunction

    function automatic int unsigned pdw_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
    parameter int unsigned     WIDTH   = 3,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= RST_VAL;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pdw_wake_detect.sv
module pdw_wake_detect
    import pdw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PDW_NUM_IN-1:0] sync_in,
    output pdw_wake_t             wake
);
    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 1'b0;
        else     stat_q <= sync_in[IDX_STAT];
    end

    always_comb begin
        wake.bus_low   = ~sync_in[IDX_BUS];
        wake.stat_rise = sync_in[IDX_STAT] & ~stat_q;
        wake.rdy_high  = sync_in[IDX_RDY];
    end
endmodule

// File: rtl/pdw_entry_gate.sv
module pdw_entry_gate (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_active,
    input  logic                ctl_pd,
    input  logic                rdy_s,
    input  logic                idle_o,
    output pdw_pkg::pdw_entry_t entry,
    output logic                first_pending
);
    logic act_q;
    logic pd_q;
    logic rdy_seen;

    always_comb begin
        entry.end_evt = act_q & ~ctl_active;
        entry.pd_ok   = entry.end_evt & pd_q & ~rdy_seen & ~rdy_s
                        & (~idle_o | first_pending);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q         <= 1'b0;
            pd_q          <= 1'b0;
            rdy_seen      <= 1'b0;
            first_pending <= 1'b1;
        end else begin
            act_q <= ctl_active;
            if (ctl_active) begin
                pd_q <= ctl_pd;
                if (rdy_s) rdy_seen <= 1'b1;
            end
            if (entry.end_evt) begin
                pd_q          <= 1'b0;
                rdy_seen      <= 1'b0;
                first_pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
    import pdw_pkg::*;
#(
    parameter int unsigned VALID_LOW_CYC  = 8,
    parameter int unsigned IDLE_PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  pdw_wake_t  wake,
    input  pdw_entry_t entry,
    output logic       core_clk_en,
    output logic       idle_o
);
    localparam int unsigned CNT_W = $clog2(pdw_max(VALID_LOW_CYC, IDLE_PULSE_CYC) + 1);
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(VALID_LOW_CYC - 2);

    pdw_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            PS_RECYCLE: begin
                if (entry.pd_ok) begin
                    state_nxt = PS_SLEEP;
                    cnt_nxt   = '0;
                end else if (cnt == IDLE_LAST) begin
                    state_nxt = PS_RUN;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            PS_RUN: begin
                if (entry.pd_ok) state_nxt = PS_SLEEP;
            end
            PS_SLEEP: begin
                cnt_nxt = '0;
                if (host_wake(wake))   state_nxt = PS_RUN;
                else if (wake.bus_low) state_nxt = PS_QUALIFY;
            end
            PS_QUALIFY: begin
                if (host_wake(wake)) begin
                    state_nxt = PS_RUN;
                    cnt_nxt   = '0;
                end else if (!wake.bus_low) begin
                    state_nxt = PS_RECYCLE;
                    cnt_nxt   = '0;
                end else if (cnt == QUAL_LAST) begin
                    state_nxt = PS_RUN;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                state_nxt = PS_RECYCLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_RECYCLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        core_clk_en = (state != PS_SLEEP);
        unique case (state)
            PS_RECYCLE, PS_QUALIFY: idle_o = 1'b1;
            PS_RUN:                 idle_o = wake.bus_low;
            default:                idle_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdw_clk_gate.sv
module pdw_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // Enable captured while clk is low, so the AND output cannot glitch
    always_ff @(negedge clk) begin
        if (rst) en_lat <= 1'b1;
        else     en_lat <= en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
    import pdw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned VALID_LOW_CYC  = 8,
    parameter int unsigned IDLE_PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rx,
    input  logic stat_strb,
    input  logic rdy_in,
    input  logic ctl_active,
    input  logic ctl_pd,
    output logic core_clk,
    output logic core_clk_en,
    output logic idle_o
);
    logic [PDW_NUM_IN-1:0] raw_in;
    logic [PDW_NUM_IN-1:0] sync_q;
    logic                  rdy_s;
    logic                  first_pending;
    pdw_wake_t             wake;
    pdw_entry_t            entry;

    always_comb begin
        raw_in           = '0;
        raw_in[IDX_BUS]  = bus_rx;
        raw_in[IDX_STAT] = stat_strb;
        raw_in[IDX_RDY]  = rdy_in;
    end

    assign rdy_s = sync_q[IDX_RDY];

    pdw_sync #(
        .WIDTH  (PDW_NUM_IN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PDW_QUIET)
    ) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
    );

    pdw_wake_detect u_wake (
        .clk(clk), .rst(rst), .sync_in(sync_q), .wake(wake)
    );

    pdw_entry_gate u_entry (
        .clk(clk), .rst(rst), .ctl_active(ctl_active), .ctl_pd(ctl_pd),
        .rdy_s(rdy_s), .idle_o(idle_o), .entry(entry),
        .first_pending(first_pending)
    );

    pdw_fsm #(
        .VALID_LOW_CYC (VALID_LOW_CYC),
        .IDLE_PULSE_CYC(IDLE_PULSE_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .wake(wake), .entry(entry),
        .core_clk_en(core_clk_en), .idle_o(idle_o)
    );

    pdw_clk_gate u_gate (
        .clk(clk), .rst(rst), .en(core_clk_en), .gclk(core_clk)
    );
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker
    import pdw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       core_clk_en,
    input logic       idle_o,
    input logic       rdy_s,
    input logic       first_pending,
    input pdw_wake_t  wake,
    input pdw_entry_t entry
);
    a_r2_stop_only_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(entry.end_evt));

    a_r3_busy_blocks_entry: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && entry.end_evt && idle_o && !first_pending) |=> core_clk_en);

    a_r4_ready_blocks_entry: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && entry.end_evt && rdy_s) |=> core_clk_en);

    a_r5_bus_low_wakes: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && wake.bus_low) |=> core_clk_en);

    a_r6_strobe_edge_wakes: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && wake.stat_rise) |=> core_clk_en);

    a_r7_ready_wakes: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && wake.rdy_high) |=> core_clk_en);
endmodule

bind pwrdn_wake_ctrl pdw_checker u_pdw_checker (
    .clk(clk), .rst(rst), .core_clk_en(core_clk_en), .idle_o(idle_o),
    .rdy_s(rdy_s), .first_pending(first_pending), .wake(wake), .entry(entry)
);

// File: tb/tb_pwrdn_wake_ctrl.sv
module tb_pwrdn_wake_ctrl;
    localparam int SEL_EN   = 0;
    localparam int SEL_IDLE = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rx = 1'b1, stat_strb = 1'b0, rdy_in = 1'b0;
    logic ctl_active = 1'b0, ctl_pd = 1'b0;
    logic core_clk, core_clk_en, idle_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int gcnt = 0;
    bit done = 0;

    typedef struct {
        int    at;
        int    sel;
        logic  v;
        string tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge core_clk) gcnt <= gcnt + 1;

    pwrdn_wake_ctrl dut (
        .clk(clk), .rst(rst), .bus_rx(bus_rx), .stat_strb(stat_strb),
        .rdy_in(rdy_in), .ctl_active(ctl_active), .ctl_pd(ctl_pd),
        .core_clk(core_clk), .core_clk_en(core_clk_en), .idle_o(idle_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue an expected value for a future sampling point
    task automatic expect_at(input int dly, input int sel, input logic v, input string tag);
        item_t it;
        it.at = cyc + dly; it.sel = sel; it.v = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic check_now(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Monitor side: compare every queued item due at this negedge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                logic a;
                a = (sb[i].sel == SEL_EN) ? core_clk_en : idle_o;
                checks++;
                if (sb[i].at < cyc || a !== sb[i].v) begin
                    errors++;
                    $display("FAIL %s: %s actual=%0b expected=%0b at cycle %0d",
                             sb[i].tag, (sb[i].sel == SEL_EN) ? "core_clk_en" : "idle_o",
                             a, sb[i].v, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic request_sleep(input string tag);
        ctl_active = 1'b1; ctl_pd = 1'b1;
        expect_at(1, SEL_EN, 1'b1, tag);
        step(1);
        ctl_active = 1'b0; ctl_pd = 1'b0;
        expect_at(1, SEL_EN, 1'b0, tag);
        expect_at(1, SEL_IDLE, 1'b0, tag);
        step(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int g0;
        // R1: reset state and the post-reset IDLE pulse
        step(1);
        expect_at(1, SEL_EN, 1'b1, "R1 reset");
        expect_at(1, SEL_IDLE, 1'b1, "R1 reset");
        step(4);
        rst = 1'b0;
        expect_at(3, SEL_IDLE, 1'b1, "R1 pulse last cycle");
        expect_at(4, SEL_IDLE, 1'b0, "R1 pulse end");
        expect_at(4, SEL_EN, 1'b1, "R1 clock on");
        step(6);

        // R3: first transfer after reset is honoured although IDLE is high
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        request_sleep("R3 first after reset");
        step(2);
        // R6: strobe rising edge wakes
        stat_strb = 1'b1;
        expect_at(2, SEL_EN, 1'b0, "R6 before latency");
        expect_at(3, SEL_EN, 1'b1, "R6 edge wake");
        expect_at(3, SEL_IDLE, 1'b0, "R6 direct resume");
        step(5);
        stat_strb = 1'b0;
        step(3);

        // R10 and R3: bus busy raises IDLE, which blocks entry
        bus_rx = 1'b0;
        expect_at(1, SEL_IDLE, 1'b0, "R10 latency");
        expect_at(2, SEL_IDLE, 1'b1, "R10 busy");
        step(3);
        ctl_active = 1'b1; ctl_pd = 1'b1;
        step(1);
        ctl_active = 1'b0; ctl_pd = 1'b0;
        expect_at(1, SEL_EN, 1'b1, "R3 blocked by IDLE");
        expect_at(2, SEL_EN, 1'b1, "R3 blocked by IDLE");
        step(3);
        bus_rx = 1'b1;
        expect_at(1, SEL_IDLE, 1'b1, "R10 latency");
        expect_at(2, SEL_IDLE, 1'b0, "R10 quiet");
        step(4);

        // R11: transfer without the power-down bit
        ctl_active = 1'b1; ctl_pd = 1'b0;
        step(1);
        ctl_active = 1'b0;
        expect_at(1, SEL_EN, 1'b1, "R11 no request");
        expect_at(3, SEL_EN, 1'b1, "R11 no request");
        step(4);

        // R4: ready high during the setting transfer cancels it
        rdy_in = 1'b1;
        step(3);
        ctl_active = 1'b1; ctl_pd = 1'b1;
        step(1);
        ctl_active = 1'b0; ctl_pd = 1'b0;
        expect_at(1, SEL_EN, 1'b1, "R4 ready cancels");
        expect_at(2, SEL_EN, 1'b1, "R4 ready cancels");
        step(2);
        rdy_in = 1'b0;
        step(4);

        // R2, R6 (level ignored), R7
        stat_strb = 1'b1;
        step(4);
        request_sleep("R2 entry at end");
        g0 = gcnt;
        step(8);
        check_now(gcnt == g0, "R2 gated clock quiet", gcnt - g0, 0);
        expect_at(1, SEL_EN, 1'b0, "R6 held strobe ignored");
        expect_at(1, SEL_IDLE, 1'b0, "R2 IDLE low asleep");
        step(2);
        rdy_in = 1'b1;
        expect_at(2, SEL_EN, 1'b0, "R7 before latency");
        expect_at(3, SEL_EN, 1'b1, "R7 ready wake");
        step(5);
        check_now(gcnt > g0, "R7 gated clock resumed", gcnt - g0, 1);
        rdy_in = 1'b0;
        stat_strb = 1'b0;
        step(4);

        // R5 and R8: short bus glitch wakes, then recycles
        request_sleep("R2 entry at end");
        step(3);
        bus_rx = 1'b0;
        expect_at(2, SEL_EN, 1'b0, "R5 before latency");
        expect_at(3, SEL_EN, 1'b1, "R5 bus wake");
        expect_at(3, SEL_IDLE, 1'b1, "R8 qualify");
        expect_at(5, SEL_IDLE, 1'b1, "R8 recycle first");
        expect_at(8, SEL_IDLE, 1'b1, "R8 recycle last");
        expect_at(9, SEL_IDLE, 1'b0, "R8 recycle end");
        step(2);
        bus_rx = 1'b1;
        step(10);

        // R9: long bus low is real activity, no recycle pulse
        request_sleep("R2 entry at end");
        step(3);
        bus_rx = 1'b0;
        expect_at(3, SEL_EN, 1'b1, "R5 bus wake");
        step(12);
        bus_rx = 1'b1;
        expect_at(1, SEL_IDLE, 1'b1, "R9 still busy");
        expect_at(2, SEL_IDLE, 1'b0, "R9 no recycle");
        expect_at(2, SEL_EN, 1'b1, "R9 running");
        step(6);

        done = 1;
        summary();
        $finish;
    end
endmodule